// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block derives the serial clock of an SPI controller from its faster module clock. A configuration word picks one of two divide laws. The power-of-two law divides by 2 raised to a 4-bit exponent. The linear law divides by twice an 8-bit value plus one. The block drives the serial clock level. It also gives the shift engine three single-cycle strobes: one for every serial clock change, one for the edge that leaves the idle level, and one for the edge that returns to it.

The divide setting and the idle level are captured when a transfer start pulse arrives, and they stay fixed until the next start pulse. The start pulse also clears the half-period counter, so the first half-period has its full length. While no transfer is active, the serial clock rests at the idle level and no strobes are issued.

Top module: `spiclk_div`

## Requirements
- R1: With bit 12 of `div_cfg` set (linear law), each serial clock half-period lasts N+1 module-clock cycles, where N is `div_cfg[7:0]`, giving a period of 2*(N+1) cycles.
- R2: With bit 12 clear (power-of-two law), the serial clock period is 2^E module-clock cycles, where E is `div_cfg[11:8]` and E is at least 1, so each half-period lasts 2^(E-1) cycles.
- R3: Under the power-of-two law, E = 0 gives the same result as E = 1: a period of 2 cycles.
- R4: `div_cfg` and `idle_level` are sampled only in a cycle where `xfer_start` is high. A change during a transfer leaves the running period unchanged until the next start pulse.
- R5: A start pulse clears the counter and puts `sclk` at the idle level. The first `sclk_toggle` then comes exactly one half-period after the start edge, even if the pulse arrives in the middle of a running transfer.
- R6: `lead_en` fires on a toggle that moves `sclk` away from the idle level, and `trail_en` fires on a toggle that moves it back. Each strobe is one cycle wide, and the two are never high together.
- R7: While `xfer_active` is low, `sclk` equals `idle_level` from the next cycle onward and no strobe is asserted. After reset, `sclk` is 0 and all strobes are low.
- R8: Every cycle with `sclk_toggle` high is followed by a change of `sclk` at the next clock edge, and `sclk` changes at no other time during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_cfg | input | 13 | Linear value [7:0], exponent [11:8], law select [12] |
| idle_level | input | 1 | Serial clock level between transfers |
| xfer_start | input | 1 | One-cycle pulse that starts a transfer and captures the setting |
| xfer_active | input | 1 | High for the duration of a transfer |
| sclk | output | 1 | Serial clock level |
| sclk_toggle | output | 1 | High in the cycle before each serial clock change |
| lead_en | output | 1 | Toggle strobe for the edge leaving the idle level |
| trail_en | output | 1 | Toggle strobe for the edge returning to the idle level |

## Verification
The linear law is exercised with N = 0, 3 and 255. These cases separate the shortest half-period, an ordinary one, and the full field width, where a truncated counter would wrap early. The power-of-two law is exercised with exponents 0, 1, 4 and 15, which separate the special case at zero, the plain divide-by-two, a mid value and the widest counter. The bench also changes the setting in the middle of a transfer and restarts a transfer while one is running; these cases show whether the setting is captured only at a start and whether the counter is cleared. Runs with idle level 0 and idle level 1 show whether the leading and trailing strobes follow the idle level rather than the absolute clock level.

// File: rtl/spiclk_pkg.sv
// Shared definitions for the serial clock divider.
// Assumes the law select bit sits directly above the exponent field.
package spiclk_pkg;
    typedef enum logic {
        LAW_POW2   = 1'b0,
        LAW_LINEAR = 1'b1
    } div_law_e;
endpackage

// File: rtl/spiclk_ratio.sv
// Converts a divider configuration word into a half-period terminal count
// (half-period length minus one). Purely combinational.
// Assumes the word layout is: linear value, then exponent, then law select.
module spiclk_ratio
    import spiclk_pkg::*;
#(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    parameter int CFG_W = LIN_W + EXP_W + 1,
    parameter int CNT_W = 14
) (
    input  logic [CFG_W-1:0] cfg_word,
    output logic [CNT_W-1:0] term
);
    localparam int EXP_LO = LIN_W;
    localparam int LAW_B  = LIN_W + EXP_W;

    logic [LIN_W-1:0] lin_val;
    logic [EXP_W-1:0] exp_val;
    div_law_e         law;

    assign lin_val = cfg_word[LIN_W-1:0];
    assign exp_val = cfg_word[EXP_LO +: EXP_W];
    assign law     = div_law_e'(cfg_word[LAW_B]);

    // Select the terminal count for the chosen law; exponent 0 acts as 1.
    always_comb begin
        if (law == LAW_LINEAR) begin
            term = CNT_W'(lin_val);
        end else if (exp_val == '0) begin
            term = '0;
        end else begin
            term = ~({CNT_W{1'b1}} << (exp_val - 1'b1));
        end
    end
endmodule

// File: rtl/spiclk_hold.sv
// Captures the terminal count and the idle level on a transfer start pulse
// and holds them for the rest of the transfer.
// Assumes xfer_start is a single-cycle pulse.
module spiclk_hold #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic [CNT_W-1:0] term_in,
    input  logic             idle_in,
    output logic [CNT_W-1:0] term_q,
    output logic             idle_q
);
    // Capture the setting only when a transfer starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_q <= '0;
            idle_q <= 1'b0;
        end else if (xfer_start) begin
            term_q <= term_in;
            idle_q <= idle_in;
        end
    end

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_start |=> ($stable(term_q) && $stable(idle_q)));
endmodule

// File: rtl/spiclk_phase.sv
// Half-period counter and serial clock register. Issues the toggle strobe
// and the leading and trailing edge strobes.
// Assumes term is stable while xfer_active is high and no start is present.
module spiclk_phase #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_start,
    input  logic             xfer_active,
    input  logic [CNT_W-1:0] term,
    input  logic             idle_live,
    input  logic             idle_held,
    output logic             sclk,
    output logic             sclk_toggle,
    output logic             lead_en,
    output logic             trail_en
);
    logic [CNT_W-1:0] cnt_q;
    logic             sclk_q;
    logic             wrap;

    assign wrap = (cnt_q == term);

    // Count the half-period and flip the serial clock at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (xfer_start || !xfer_active) begin
            cnt_q  <= '0;
            sclk_q <= idle_live;
        end else if (wrap) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Decode the strobes from the wrap point and the current level.
    always_comb begin
        sclk_toggle = xfer_active && !xfer_start && wrap;
        lead_en     = sclk_toggle && (sclk_q == idle_held);
        trail_en    = sclk_toggle && (sclk_q != idle_held);
    end

    assign sclk = sclk_q;

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !xfer_start) |-> (cnt_q <= term));
    assert_start_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> (cnt_q == '0));
    assert_one_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lead_en, trail_en}));
    assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> (sclk_q == $past(idle_live)));
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |-> !sclk_toggle);
    assert_toggle_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_toggle |=> (sclk_q != $past(sclk_q)));
endmodule

// File: rtl/spiclk_div.sv
// Top of the dual-law serial clock divider: ratio decode, setting capture
// and half-period phase generation.
// Assumes the module clock runs at least twice as fast as the serial clock.
module spiclk_div #(
    parameter int LIN_W = 8,
    parameter int EXP_W = 4,
    localparam int CFG_W   = LIN_W + EXP_W + 1,
    localparam int EXP_MAX = (1 << EXP_W) - 1,
    localparam int CNT_W   = ((EXP_MAX - 1) > LIN_W) ? (EXP_MAX - 1) : LIN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] div_cfg,
    input  logic             idle_level,
    input  logic             xfer_start,
    input  logic             xfer_active,
    output logic             sclk,
    output logic             sclk_toggle,
    output logic             lead_en,
    output logic             trail_en
);
    logic [CNT_W-1:0] term_next;
    logic [CNT_W-1:0] term_held;
    logic             idle_held;

    spiclk_ratio #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CFG_W(CFG_W), .CNT_W(CNT_W)) u_ratio (
        .cfg_word (div_cfg),
        .term     (term_next)
    );

    spiclk_hold #(.CNT_W(CNT_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .term_in    (term_next),
        .idle_in    (idle_level),
        .term_q     (term_held),
        .idle_q     (idle_held)
    );

    spiclk_phase #(.CNT_W(CNT_W)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_start  (xfer_start),
        .xfer_active (xfer_active),
        .term        (term_held),
        .idle_live   (idle_level),
        .idle_held   (idle_held),
        .sclk        (sclk),
        .sclk_toggle (sclk_toggle),
        .lead_en     (lead_en),
        .trail_en    (trail_en)
    );
endmodule

// File: tb/spiclk_div_bench.sv
module spiclk_div_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] div_cfg = '0;
    logic        idle_level = 1'b0;
    logic        xfer_start = 1'b0;
    logic        xfer_active = 1'b0;
    logic        sclk, sclk_toggle, lead_en, trail_en;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    spiclk_div u_spiclk_div (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .idle_level(idle_level),
        .xfer_start(xfer_start), .xfer_active(xfer_active), .sclk(sclk),
        .sclk_toggle(sclk_toggle), .lead_en(lead_en), .trail_en(trail_en)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Start a transfer and count toggles; w_mid is applied one cycle after start.
    task automatic run_xfer(input logic [12:0] w, input logic [12:0] w_mid, input logic idl,
                            input int half, input int ntog, input string rq);
        int seen = 0; int bad_iv = 0; int bad_edge = 0; int bad_lvl = 0;
        logic lvl = idl;
        @(negedge clk);
        div_cfg = w; idle_level = idl; xfer_start = 1'b1; xfer_active = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        div_cfg = w_mid;
        for (int i = 1; i <= ntog * half; i++) begin
            #1;
            if (sclk !== lvl) bad_lvl++;
            if (sclk_toggle === 1'b1) begin
                if (i % half != 0) bad_iv++;
                if (lead_en !== (lvl == idl) || trail_en !== (lvl != idl)) bad_edge++;
                seen++;
                lvl = ~lvl;
            end else if (lead_en !== 1'b0 || trail_en !== 1'b0) begin
                bad_edge++;
            end
            if (i != ntog * half) @(negedge clk);
        end
        check(seen == ntog, {rq, " toggle count"}, seen, ntog);
        check(bad_iv == 0, {rq, " R5 toggle spacing"}, bad_iv, 0);
        check(bad_edge == 0, {rq, " R6 lead/trail strobes"}, bad_edge, 0);
        check(bad_lvl == 0, {rq, " R8 sclk level"}, bad_lvl, 0);
    endtask

    task automatic test_reset();
        #1;
        check(sclk === 1'b0, "R7 reset sclk", int'(sclk), 0);
        check({sclk_toggle, lead_en, trail_en} === 3'b000, "R7 reset strobes",
              int'({sclk_toggle, lead_en, trail_en}), 0);
    endtask

    task automatic test_linear();
        run_xfer(13'h1000, 13'h1000, 1'b0, 1, 4, "R1 N=0");
        run_xfer(13'h1003, 13'h1003, 1'b0, 4, 4, "R1 N=3");
        run_xfer(13'h10FF, 13'h10FF, 1'b0, 256, 3, "R1 N=255");
    endtask

    task automatic test_pow2();
        run_xfer(13'h00AB, 13'h00AB, 1'b0, 1, 4, "R3 E=0");
        run_xfer(13'h0100, 13'h0100, 1'b0, 1, 4, "R2 E=1");
        run_xfer(13'h0400, 13'h0400, 1'b0, 8, 4, "R2 E=4");
        run_xfer(13'h0F00, 13'h0F00, 1'b0, 16384, 2, "R2 E=15");
    endtask

    task automatic test_idle_high();
        run_xfer(13'h1002, 13'h1002, 1'b1, 3, 4, "R6 idle=1");
    endtask

    task automatic test_mid_change();
        run_xfer(13'h1001, 13'h1009, 1'b0, 2, 6, "R4 change ignored");
        run_xfer(13'h1009, 13'h1009, 1'b0, 10, 2, "R4 next start");
    endtask

    task automatic test_restart();
        run_xfer(13'h1005, 13'h1005, 1'b0, 6, 1, "R5 pre");
        repeat (3) @(negedge clk);
        run_xfer(13'h1005, 13'h1005, 1'b0, 6, 3, "R5 restart");
    endtask

    task automatic test_inactive(input logic idl);
        int bad = 0;
        @(negedge clk);
        idle_level = idl; xfer_active = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            div_cfg = 13'(i * 37);
            #1;
            if (sclk !== idl || sclk_toggle !== 1'b0 || lead_en !== 1'b0 || trail_en !== 1'b0) bad++;
        end
        check(bad == 0, "R7 inactive idle and quiet", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_linear();
        test_pow2();
        test_idle_high();
        test_mid_change();
        test_restart();
        test_inactive(1'b1);
        test_inactive(1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
            $finish;
        end
    end
endmodule